// File: doc/BRIEF.md
# Single-Cycle 8-Bit Processor Core

This block is a small processor that executes one 8-bit instruction on every rising clock edge. It holds an 8-bit program counter, two 8-bit general registers, a 256-entry instruction store and a separate 16-entry data store. The ALU does add, subtract, OR and AND. The instruction set covers register-register arithmetic, load and store at a 4-bit address, load-upper-immediate, OR-immediate, an unconditional jump, a jump taken when the two registers are equal, and halt. Both jumps replace only the low four bits of the program counter and keep the upper four.

A host fills the instruction store through a write port while reset is held low. After reset is released, the core spends one start-up edge leaving the idle state. Execution then begins at address 0 and continues until a halt instruction is fetched. A combinational debug port reads any data-store word at any time, so results can be collected. The `halted_o` output shows that the fetched instruction is a halt.

Instruction layout: bits [7:5] are the opcode and bit [4] is the destination register. For opcode 0, bit [3] selects source A, bit [2] selects source B and bits [1:0] select the function. For every other opcode, bits [3:0] are a 4-bit immediate.

Top module: `cpu8_core`

## Requirements
- R1: When `rst_ni` goes low, the program counter and both registers clear to zero at once. While `rst_ni` stays low, nothing executes. On the first rising edge after release nothing executes either. Each later rising edge executes exactly one instruction.
- R2: Instruction-store writes (`imem_we_i`) take effect only before execution starts, meaning while `rst_ni` is low or on the start-up edge. Once the core is executing they are ignored.
- R3: Opcode 0 writes `f(R[bit3], R[bit2])` into `R[bit4]`, modulo 256. The function code is 0 for add, 1 for subtract, 2 for OR and 3 for AND.
- R4: Opcode 5 (load upper) writes `{imm, 4'b0000}` into the destination register.
- R5: Opcode 6 (OR immediate) writes the destination register OR'd with the zero-extended immediate back into that register.
- R6: Opcode 3 loads data word `imm` into the destination register. Opcode 4 stores the destination register into data word `imm`. The debug port returns data word `dbg_addr_i` combinationally.
- R7: Opcode 1 compares R0 with R1. If they are equal, the PC becomes `{PC[7:4], imm}`; otherwise the PC becomes PC+1.
- R8: Opcode 2 sets the PC to `{PC[7:4], imm}`.
- R9: Opcode 7 (halt), with any values in bits [4:0], changes no register, no data word and not the PC. `halted_o` is high while the fetched opcode is 7.
- R10: Every instruction other than a jump or a halt advances the PC by one, modulo 256, so address 255 is followed by address 0.
- R11: A program built only from this instruction set writes `n` to data word 0. It then reads `n` back from data word 0 and stores `n*(n+1)/2 mod 256` into data word 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_we_i | input | 1 | Instruction-store write enable, honoured only before execution starts |
| imem_waddr_i | input | 8 | Instruction-store write address |
| imem_wdata_i | input | 8 | Instruction-store write data |
| dbg_addr_i | input | 4 | Data-store debug read address |
| dbg_data_o | output | 8 | Data word at `dbg_addr_i` |
| pc_o | output | 8 | Current program counter |
| halted_o | output | 1 | Fetched opcode is halt |

## Verification
The registers have no output of their own. A wrong register value therefore becomes visible only when a later store writes it to the data store and the debug port reads it back. That happens one instruction after the faulty write at the earliest, or much later in the looping sum program. A wrong next-PC shows on `pc_o` at the very next edge: a missed jump, a wrong page after a jump, or a halt that fails to hold. A leaked instruction-store write or an execution during the start-up edge shows as a program that halts at the wrong address or leaves an expected data word unwritten.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;
  localparam int XLEN  = 8;
  localparam int IMM_W = 4;

  typedef enum logic [2:0] {
    OP_RR  = 3'd0,
    OP_JEQ = 3'd1,
    OP_JMP = 3'd2,
    OP_LD  = 3'd3,
    OP_ST  = 3'd4,
    OP_LUI = 3'd5,
    OP_ORI = 3'd6,
    OP_HLT = 3'd7
  } opcode_e;

  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_SUB = 2'd1,
    FN_OR  = 2'd2,
    FN_AND = 2'd3
  } alu_fn_e;

  typedef enum logic [1:0] {
    WB_ALU = 2'd0,
    WB_MEM = 2'd1,
    WB_LUI = 2'd2
  } wb_sel_e;

  typedef enum logic [1:0] {
    NPC_INC  = 2'd0,
    NPC_JMP  = 2'd1,
    NPC_JEQ  = 2'd2,
    NPC_HOLD = 2'd3
  } npc_sel_e;

  typedef struct packed {
    opcode_e          op;
    logic             rd;
    logic             ra;
    logic             rb;
    alu_fn_e          fn;
    logic [IMM_W-1:0] imm;
    logic             b_imm;
    logic             rf_we;
    wb_sel_e          wb;
    logic             dm_we;
    npc_sel_e         npc;
  } ctrl_t;
endpackage

// File: rtl/cpu8_decoder.sv
module cpu8_decoder
  import cpu8_pkg::*;
(
  input  logic [XLEN-1:0] instr_i,
  output ctrl_t           ctrl_o
);
  always_comb begin
    ctrl_o       = '0;
    ctrl_o.op    = opcode_e'(instr_i[7:5]);
    ctrl_o.rd    = instr_i[4];
    ctrl_o.ra    = instr_i[4];
    ctrl_o.rb    = instr_i[4];
    ctrl_o.imm   = instr_i[IMM_W-1:0];
    ctrl_o.fn    = FN_OR;
    ctrl_o.wb    = WB_ALU;
    ctrl_o.npc   = NPC_INC;
    unique case (ctrl_o.op)
      OP_RR: begin
        ctrl_o.ra    = instr_i[3];
        ctrl_o.rb    = instr_i[2];
        ctrl_o.fn    = alu_fn_e'(instr_i[1:0]);
        ctrl_o.rf_we = 1'b1;
      end
      OP_JEQ: begin
        // equality test always reads R0 against R1
        ctrl_o.ra  = 1'b0;
        ctrl_o.rb  = 1'b1;
        ctrl_o.npc = NPC_JEQ;
      end
      OP_JMP: ctrl_o.npc = NPC_JMP;
      OP_LD: begin
        ctrl_o.rf_we = 1'b1;
        ctrl_o.wb    = WB_MEM;
      end
      OP_ST:  ctrl_o.dm_we = 1'b1;
      OP_LUI: begin
        ctrl_o.rf_we = 1'b1;
        ctrl_o.wb    = WB_LUI;
      end
      OP_ORI: begin
        ctrl_o.rf_we = 1'b1;
        ctrl_o.b_imm = 1'b1;
      end
      OP_HLT: ctrl_o.npc = NPC_HOLD;
      default: ;
    endcase
  end
endmodule

// File: rtl/cpu8_regfile.sv
module cpu8_regfile #(
  parameter int W    = 8,
  parameter int NREG = 2,
  localparam int AW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_addr_i,
  input  logic [AW-1:0] rb_addr_i,
  output logic [W-1:0]  ra_data_o,
  output logic [W-1:0]  rb_data_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i
);
  logic [W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        regs_q[g] <= '0;
      else if (we_i && wa_i == AW'(g))    regs_q[g] <= wd_i;
    end
  end

  assign ra_data_o = regs_q[ra_addr_i];
  assign rb_data_o = regs_q[rb_addr_i];

  // R3: a committed write is readable on the following cycle
  a_r3_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> regs_q[$past(wa_i)] == $past(wd_i));
endmodule

// File: rtl/cpu8_alu.sv
module cpu8_alu
  import cpu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_fn_e      fn_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    unique case (fn_i)
      FN_ADD:  y_o = a_i + b_i;
      FN_SUB:  y_o = a_i - b_i;
      FN_OR:   y_o = a_i | b_i;
      FN_AND:  y_o = a_i & b_i;
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/cpu8_dmem.sv
module cpu8_dmem #(
  parameter int W  = 8,
  parameter int AW = 4,
  localparam int DEPTH = 2 ** AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  input  logic [AW-1:0] dbg_addr_i,
  output logic [W-1:0]  dbg_data_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o    = mem_q[addr_i];
  assign dbg_data_o = mem_q[dbg_addr_i];

  // R6: a store is visible at its address on the next cycle
  a_r6_store_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(addr_i)] == $past(wdata_i));
endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
  import cpu8_pkg::*;
#(
  parameter int IMEM_AW = 8,
  parameter int DMEM_AW = 4,
  parameter int NREG    = 2,
  localparam int IMEM_DEPTH = 2 ** IMEM_AW,
  localparam int PAGE_W     = IMEM_AW - IMM_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               imem_we_i,
  input  logic [IMEM_AW-1:0] imem_waddr_i,
  input  logic [XLEN-1:0]    imem_wdata_i,
  input  logic [DMEM_AW-1:0] dbg_addr_i,
  output logic [XLEN-1:0]    dbg_data_o,
  output logic [IMEM_AW-1:0] pc_o,
  output logic               halted_o
);
  logic               run_q;
  logic [IMEM_AW-1:0] pc_q, pc_d, pc_inc, pc_tgt;
  logic [XLEN-1:0]    imem_q [IMEM_DEPTH];
  logic [XLEN-1:0]    instr;
  ctrl_t              ctrl;
  logic [XLEN-1:0]    ra_data, rb_data, alu_b, alu_y, dm_rdata, wb_data;
  logic               rf_we, dm_we;

  // start-up flag keeps reset purely asynchronous and gates the first edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (!run_q && imem_we_i) imem_q[imem_waddr_i] <= imem_wdata_i;
  end

  assign instr = imem_q[pc_q];

  cpu8_decoder u_dec (
    .instr_i (instr),
    .ctrl_o  (ctrl)
  );

  assign rf_we = run_q & ctrl.rf_we;
  assign dm_we = run_q & ctrl.dm_we;

  cpu8_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ra_addr_i (ctrl.ra),
    .rb_addr_i (ctrl.rb),
    .ra_data_o (ra_data),
    .rb_data_o (rb_data),
    .we_i      (rf_we),
    .wa_i      (ctrl.rd),
    .wd_i      (wb_data)
  );

  assign alu_b = ctrl.b_imm ? XLEN'(ctrl.imm) : rb_data;

  cpu8_alu #(.W(XLEN)) u_alu (
    .a_i  (ra_data),
    .b_i  (alu_b),
    .fn_i (ctrl.fn),
    .y_o  (alu_y)
  );

  cpu8_dmem #(.W(XLEN), .AW(DMEM_AW)) u_dmem (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (dm_we),
    .addr_i     (DMEM_AW'(ctrl.imm)),
    .wdata_i    (ra_data),
    .rdata_o    (dm_rdata),
    .dbg_addr_i (dbg_addr_i),
    .dbg_data_o (dbg_data_o)
  );

  always_comb begin
    unique case (ctrl.wb)
      WB_MEM:  wb_data = dm_rdata;
      WB_LUI:  wb_data = {ctrl.imm, {(XLEN-IMM_W){1'b0}}};
      default: wb_data = alu_y;
    endcase
  end

  assign pc_inc = pc_q + IMEM_AW'(1);
  assign pc_tgt = {pc_q[IMEM_AW-1 -: PAGE_W], ctrl.imm};

  always_comb begin
    unique case (ctrl.npc)
      NPC_JMP:  pc_d = pc_tgt;
      NPC_JEQ:  pc_d = (ra_data == rb_data) ? pc_tgt : pc_inc;
      NPC_HOLD: pc_d = pc_q;
      default:  pc_d = pc_inc;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pc_q <= '0;
    else if (run_q) pc_q <= pc_d;
  end

  assign pc_o     = pc_q;
  assign halted_o = (ctrl.op == OP_HLT);

  a_r9_halt_holds_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && halted_o) |=> pc_q == $past(pc_q));

  a_r9_halt_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !(rf_we || dm_we));

  a_r10_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && ctrl.npc == NPC_INC) |=> pc_q == $past(pc_q) + IMEM_AW'(1));

  a_r8_jump_same_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && ctrl.npc == NPC_JMP) |=>
      pc_q[IMEM_AW-1 -: PAGE_W] == $past(pc_q[IMEM_AW-1 -: PAGE_W]));

  a_r2_imem_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && imem_we_i) |=> imem_q[$past(imem_waddr_i)] == $past(imem_q[imem_waddr_i]));
endmodule

// File: tb/cpu8_core_tb.sv
module cpu8_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b1;
  logic       imem_we = 1'b0;
  logic [7:0] imem_waddr = '0;
  logic [7:0] imem_wdata = '0;
  logic [3:0] dbg_addr = '0;
  logic [7:0] dbg_data;
  logic [7:0] pc;
  logic       halted;

  int checks = 0;
  int fails  = 0;
  logic [7:0] prog [256];

  cpu8_core dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .imem_we_i    (imem_we),
    .imem_waddr_i (imem_waddr),
    .imem_wdata_i (imem_wdata),
    .dbg_addr_i   (dbg_addr),
    .dbg_data_o   (dbg_data),
    .pc_o         (pc),
    .halted_o     (halted)
  );

  always #10 clk = ~clk;

  // {swap, func, a, b, expected}; swap puts the result in R1 as f(R1, R0)
  localparam logic [26:0] ALU_VEC [9] = '{
    {1'b0, 2'd0, 8'h25, 8'h13, 8'h38},
    {1'b0, 2'd0, 8'hF0, 8'h20, 8'h10},
    {1'b0, 2'd1, 8'h50, 8'h21, 8'h2F},
    {1'b0, 2'd1, 8'h05, 8'h07, 8'hFE},
    {1'b1, 2'd1, 8'h50, 8'h21, 8'hD1},
    {1'b0, 2'd2, 8'hA0, 8'h0C, 8'hAC},
    {1'b0, 2'd3, 8'hF3, 8'h3E, 8'h32},
    {1'b0, 2'd3, 8'h0F, 8'hF0, 8'h00},
    {1'b1, 2'd0, 8'h7F, 8'h01, 8'h80}
  };

  task automatic check8(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic rd_dmem(input logic [3:0] a, output logic [7:0] d);
    dbg_addr = a;
    #1;
    d = dbg_data;
  endtask

  task automatic start_prog(input int len);
    rst_ni = 1'b0;
    @(negedge clk);
    for (int i = 0; i < len; i++) begin
      imem_we = 1'b1; imem_waddr = 8'(i); imem_wdata = prog[i];
      @(negedge clk);
    end
    imem_we = 1'b0;
    check8("R1", "pc in reset", pc, 8'h00);
    rst_ni = 1'b1;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_sum(input logic [7:0] n);
    logic [7:0] d;
    int exp_sum;
    exp_sum = (int'(n) * (int'(n) + 1) / 2) % 256;
    for (int i = 0; i < 256; i++) prog[i] = 8'hD0;
    prog[8'h00] = {3'b101, 1'b0, n[7:4]};
    prog[8'h01] = {3'b110, 1'b0, n[3:0]};
    prog[8'h02] = 8'h80;  // store r0,0
    prog[8'h03] = 8'hA0;
    prog[8'h04] = 8'h81;  // acc = 0
    prog[8'h05] = 8'hB0;
    prog[8'h06] = 8'hD1;
    prog[8'h07] = 8'h92;  // const 1
    prog[8'h10] = 8'h60;  // load n
    prog[8'h11] = 8'hB0;
    prog[8'h12] = 8'h2A;  // jeq end
    prog[8'h13] = 8'h71;
    prog[8'h14] = 8'h18;  // add r1,r1,r0
    prog[8'h15] = 8'h91;
    prog[8'h16] = 8'h72;
    prog[8'h17] = 8'h05;  // sub r0,r0,r1
    prog[8'h18] = 8'h80;
    prog[8'h19] = 8'h40;  // j loop
    prog[8'h1A] = 8'h61;
    prog[8'h1B] = 8'h8F;
    prog[8'h1C] = 8'hE0;
    start_prog(8'h1D);
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if (halted) break;
    end
    check8("R11", "sum halt pc", pc, 8'h1C);
    rd_dmem(4'hF, d); check8("R11", "sum result", d, 8'(exp_sum));
    rd_dmem(4'h0, d); check8("R11", "counter at zero", d, 8'h00);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    #1;

    // R3: vector table
    foreach (ALU_VEC[k]) begin
      logic       sw;
      logic [1:0] fn;
      logic [7:0] a, b, e;
      {sw, fn, a, b, e} = ALU_VEC[k];
      prog[0] = {3'b101, 1'b0, a[7:4]};
      prog[1] = {3'b110, 1'b0, a[3:0]};
      prog[2] = {3'b101, 1'b1, b[7:4]};
      prog[3] = {3'b110, 1'b1, b[3:0]};
      prog[4] = sw ? {3'b000, 1'b1, 1'b1, 1'b0, fn} : {3'b000, 1'b0, 1'b0, 1'b1, fn};
      prog[5] = {3'b100, sw, 4'd3};
      prog[6] = 8'hE0;
      start_prog(7);
      step(9);
      rd_dmem(4'd3, d);
      check8("R3", $sformatf("alu vec %0d", k), d, e);
      check8("R9", "halt pc after alu", pc, 8'h06);
    end

    // R4 R5 R9: lui / ori, halt with nonzero low bits
    prog[0] = 8'hA9; prog[1] = 8'h84; prog[2] = 8'hC6; prog[3] = 8'h85;
    prog[4] = 8'hBF; prog[5] = 8'hD3; prog[6] = 8'h96; prog[7] = 8'hF4;
    start_prog(8);
    step(12);
    rd_dmem(4'd4, d); check8("R4", "lui nibble", d, 8'h90);
    rd_dmem(4'd5, d); check8("R5", "ori merge", d, 8'h96);
    rd_dmem(4'd6, d); check8("R5", "ori keeps upper", d, 8'hF3);
    check8("R9", "halt pc", pc, 8'h07);
    check8("R9", "halted flag", 8'(halted), 8'h01);
    step(4);
    rd_dmem(4'd4, d); check8("R9", "halt stored nothing", d, 8'h90);
    check8("R9", "halt pc stable", pc, 8'h07);

    // R1: registers cleared by reset
    prog[0] = 8'hA5; prog[1] = 8'h87; prog[2] = 8'h88; prog[3] = 8'hE0;
    start_prog(4);
    step(6);
    rd_dmem(4'd7, d); check8("R6", "store r0 to 7", d, 8'h50);
    prog[0] = 8'h87; prog[1] = 8'h98; prog[2] = 8'hE0;
    start_prog(3);
    step(5);
    rd_dmem(4'd7, d); check8("R1", "r0 after reset", d, 8'h00);
    rd_dmem(4'd8, d); check8("R1", "r1 after reset", d, 8'h00);

    // R7: jeq not taken then taken
    prog[0] = 8'hA0; prog[1] = 8'hB1; prog[2] = 8'h25; prog[3] = 8'hB0;
    prog[4] = 8'h28; prog[5] = 8'hE0; prog[6] = 8'hE0; prog[7] = 8'hE0;
    prog[8] = 8'hE0;
    start_prog(9);
    step(4);
    check8("R7", "jeq not taken", pc, 8'h03);
    step(2);
    check8("R7", "jeq taken", pc, 8'h08);
    // R1: asynchronous clear of pc
    rst_ni = 1'b0;
    #1;
    check8("R1", "async pc clear", pc, 8'h00);

    // R2: write while running is ignored; R6 load/store path
    prog[0] = 8'hA1; prog[1] = 8'h89; prog[2] = 8'hE0;
    start_prog(3);
    step(1);
    imem_we = 1'b1; imem_waddr = 8'h01; imem_wdata = 8'hE0;
    @(negedge clk);
    imem_we = 1'b0;
    step(3);
    check8("R2", "running write ignored pc", pc, 8'h02);
    rd_dmem(4'd9, d); check8("R2", "store still ran", d, 8'h10);

    // R8 R10: jump within page, increment wraps 255 -> 0
    for (int i = 0; i < 256; i++) prog[i] = 8'hD0;
    prog[8'h35] = 8'h49;
    start_prog(256);
    step(55);
    check8("R8", "j keeps upper nibble", pc, 8'h39);
    step(198);
    check8("R10", "pc reaches 255", pc, 8'hFF);
    step(1);
    check8("R10", "pc wraps to 0", pc, 8'h00);

    // R11 R6: sum program, with and without result wrap
    run_sum(8'd10);
    run_sum(8'd23);
    step(5);
    check8("R9", "pc held after sum halt", pc, 8'h1C);
    rd_dmem(4'hF, d); check8("R9", "result unchanged in halt", d, 8'd20);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule